// File: doc/BRIEF.md
# Trace Line Buffer with Fill Counter

This block is the storage half of an on-chip debug tracer. A capture session is opened by an arm pulse. Each store strobe during the session writes one 20-bit trace line into a 64-entry circular memory. A 6-bit fill counter tracks how many lines have been captured. When the counter rolls over, a sticky full flag is set, and from then on every entry is treated as valid.

Two alignment modes set what happens when the buffer fills:
- **Begin-aligned:** the session stops by itself after the 64th line.
- **End-aligned:** capture keeps going, and each new line overwrites the oldest one.

A read strobe returns lines oldest-first without changing the counter.

Two resets behave differently. Power-on reset clears all status. A system reset only ends the session, so the capture history stays readable after a crash.

Top module: `trace_fill_buf`

## Requirements
- R1: After power-on reset, the fill count is 0, the full flag is 0 and the session is not armed.
- R2: While armed, each store strobe writes one line and adds one to the count. While not armed, store strobes are ignored: the count stays the same and no line is written.
- R3: A store that moves the count from 63 to 0 sets the full flag. The flag stays set until the next arm pulse or power-on reset.
- R4: In end-aligned mode (align_end_i=1), the session stays armed after the full flag is set. Storing continues, the count keeps incrementing, and each new line overwrites the oldest.
- R5: In begin-aligned mode (align_end_i=0), the store that completes the 64th line disarms the session. Later stores are ignored.
- R6: An arm pulse clears the count and the full flag and sets armed. It takes priority over a store strobe in the same cycle, and that store is dropped.
- R7: A system reset (sys_rst_n low at a clock edge) disarms the session and keeps the count, the full flag and the stored lines. It takes priority over arm and store.
- R8: Each read strobe produces rd_valid_o and rd_data_o in the next cycle. The first read after an arm pulse, disarm pulse, accepted store or system reset returns the oldest line: entry 0 if the full flag is clear, otherwise the entry at the current count. Each later read returns the next entry, modulo 64.
- R9: Reading does not change the count, the full flag or the stored lines.
- R10: cnt_reg_o holds the full flag at bit 7, 0 at bit 6 and the count at bits 5:0. stat_reg_o holds the full flag at bit 7, armed at bit 0 and 0 elsewhere.
- R11: A disarm pulse (arm_clr_i) clears armed and leaves the count and the full flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, active low |
| arm_set_i | input | 1 | Arm pulse: start a new session |
| arm_clr_i | input | 1 | Disarm pulse |
| align_end_i | input | 1 | 1 = end-aligned, 0 = begin-aligned |
| store_i | input | 1 | Store strobe |
| store_data_i | input | 20 | Trace line to store |
| rd_req_i | input | 1 | Read strobe |
| rd_data_o | output | 20 | Line read out |
| rd_valid_o | output | 1 | rd_data_o is valid |
| armed_o | output | 1 | Session armed |
| cnt_reg_o | output | 8 | Count register view |
| stat_reg_o | output | 8 | Status register view |

## Verification
Assertions check the following on every cycle:
- the counter holds still while disarmed and while reading;
- the counter steps by one on each accepted store;
- the full flag is sticky;
- the mode-dependent disarm or continuation happens at rollover;
- an arm pulse clears the counter and flag;
- a read is answered one cycle later.

Only the bench scenarios can show the following:
- the order of data returned after overwrite;
- that ignored stores leave memory contents untouched;
- that status and lines survive a system reset;
- the register bit layouts.

// File: rtl/trbuf_pkg.sv
package trbuf_pkg;
   typedef enum logic {
      ALIGN_BEGIN = 1'b0,
      ALIGN_END   = 1'b1
   } align_e;

   localparam int unsigned DEF_LINE_W = 20;
   localparam int unsigned DEF_ADDR_W = 6;
endpackage

// File: rtl/trbuf_line_ram.sv
module trbuf_line_ram #(
   parameter int unsigned LINE_W  = 20,
   parameter int unsigned ADDR_W  = 6,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [LINE_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [LINE_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [LINE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (REG_OUT) begin : g_data_reg
         logic [LINE_W-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (re) rdata_q <= mem[raddr];
         end
         assign rdata = rdata_q;
      end else begin : g_addr_reg
         logic [ADDR_W-1:0] raddr_q;
         always_ff @(posedge clk) begin
            if (re) raddr_q <= raddr;
         end
         assign rdata = mem[raddr_q];
      end
   endgenerate
endmodule

// File: rtl/trbuf_fill_ctrl.sv
module trbuf_fill_ctrl #(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              arm_set_i,
   input  logic              arm_clr_i,
   input  trbuf_pkg::align_e align_i,
   input  logic              store_i,
   output logic              accept_o,
   output logic [ADDR_W-1:0] cnt_o,
   output logic              full_o,
   output logic              armed_o
);
   import trbuf_pkg::*;

   localparam logic [ADDR_W-1:0] CNT_MAX = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] CNT_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic [ADDR_W-1:0] cnt_q;
   logic              full_q;
   logic              armed_q;
   logic              wrap;

   assign accept_o = sys_rst_n && !arm_set_i && armed_q && store_i;
   assign wrap     = accept_o && (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q   <= '0;
         full_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (!sys_rst_n) begin
         armed_q <= 1'b0;
      end else if (arm_set_i) begin
         cnt_q   <= '0;
         full_q  <= 1'b0;
         armed_q <= 1'b1;
      end else begin
         if (accept_o) cnt_q <= cnt_q + CNT_ONE;
         if (wrap) full_q <= 1'b1;
         if (arm_clr_i || (wrap && align_i == ALIGN_BEGIN)) armed_q <= 1'b0;
      end
   end

   assign cnt_o   = cnt_q;
   assign full_o  = full_q;
   assign armed_o = armed_q;

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!armed_q && !arm_set_i) |=> $stable(cnt_q));

   // R2
   step_one_chk: assert property (@(posedge clk) disable iff (!por_n)
      (armed_q && store_i && !arm_set_i && sys_rst_n) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

   // R3
   full_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      (full_q && !(arm_set_i && sys_rst_n)) |=> full_q);

   // R3
   wrap_full_chk: assert property (@(posedge clk) disable iff (!por_n)
      (armed_q && store_i && !arm_set_i && sys_rst_n && cnt_q == CNT_MAX) |=> (full_q && cnt_q == '0));

   // R4
   end_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      (armed_q && store_i && !arm_set_i && !arm_clr_i && sys_rst_n && cnt_q == CNT_MAX
       && align_i == ALIGN_END) |=> armed_q);

   // R5
   begin_stop_chk: assert property (@(posedge clk) disable iff (!por_n)
      (armed_q && store_i && !arm_set_i && sys_rst_n && cnt_q == CNT_MAX
       && align_i == ALIGN_BEGIN) |=> !armed_q);

   // R6
   arm_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      (arm_set_i && sys_rst_n) |=> (cnt_q == '0 && !full_q && armed_q));

   // R7
   sys_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      !sys_rst_n |=> (!armed_q && $stable(cnt_q) && $stable(full_q)));
endmodule

// File: rtl/trbuf_read_seq.sv
module trbuf_read_seq #(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              rewind_i,
   input  logic              rd_req_i,
   input  logic [ADDR_W-1:0] cnt_i,
   input  logic              full_i,
   output logic [ADDR_W-1:0] raddr_o,
   output logic              rd_valid_o
);
   localparam logic [ADDR_W-1:0] IDX_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic [ADDR_W-1:0] idx_q;
   logic [ADDR_W-1:0] oldest;
   logic              valid_q;

   assign oldest  = full_i ? cnt_i : '0;
   assign raddr_o = oldest + idx_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         idx_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= rd_req_i;
         if (!sys_rst_n || rewind_i) idx_q <= '0;
         else if (rd_req_i)          idx_q <= idx_q + IDX_ONE;
      end
   end

   assign rd_valid_o = valid_q;

   // R8
   rd_answer_chk: assert property (@(posedge clk) disable iff (!por_n)
      rd_req_i |=> rd_valid_o);

   // R8
   rd_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
      !rd_req_i |=> !rd_valid_o);
endmodule

// File: rtl/trace_fill_buf.sv
module trace_fill_buf #(
   parameter int unsigned LINE_W  = trbuf_pkg::DEF_LINE_W,
   parameter int unsigned ADDR_W  = trbuf_pkg::DEF_ADDR_W,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                sys_rst_n,
   input  logic                arm_set_i,
   input  logic                arm_clr_i,
   input  logic                align_end_i,
   input  logic                store_i,
   input  logic [LINE_W-1:0]   store_data_i,
   input  logic                rd_req_i,
   output logic [LINE_W-1:0]   rd_data_o,
   output logic                rd_valid_o,
   output logic                armed_o,
   output logic [ADDR_W+1:0]   cnt_reg_o,
   output logic [ADDR_W+1:0]   stat_reg_o
);
   import trbuf_pkg::*;

   localparam int unsigned REG_W = ADDR_W + 2;

   generate
      if (LINE_W < 1) begin : g_bad_line
         $error("trace_fill_buf: LINE_W must be at least 1");
      end
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
         $error("trace_fill_buf: ADDR_W must be within 2..12");
      end
   endgenerate

   logic              accept;
   logic [ADDR_W-1:0] cnt;
   logic              full;
   logic              armed;
   logic [ADDR_W-1:0] raddr;
   logic              rewind;
   align_e            align;

   assign align  = align_end_i ? ALIGN_END : ALIGN_BEGIN;
   assign rewind = arm_set_i || arm_clr_i || accept;

   trbuf_fill_ctrl #(.ADDR_W(ADDR_W)) u_fill (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .arm_set_i (arm_set_i),
      .arm_clr_i (arm_clr_i),
      .align_i   (align),
      .store_i   (store_i),
      .accept_o  (accept),
      .cnt_o     (cnt),
      .full_o    (full),
      .armed_o   (armed)
   );

   trbuf_read_seq #(.ADDR_W(ADDR_W)) u_rd (
      .clk        (clk),
      .por_n      (por_n),
      .sys_rst_n  (sys_rst_n),
      .rewind_i   (rewind),
      .rd_req_i   (rd_req_i),
      .cnt_i      (cnt),
      .full_i     (full),
      .raddr_o    (raddr),
      .rd_valid_o (rd_valid_o)
   );

   trbuf_line_ram #(.LINE_W(LINE_W), .ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_ram (
      .clk   (clk),
      .we    (accept),
      .waddr (cnt),
      .wdata (store_data_i),
      .re    (rd_req_i),
      .raddr (raddr),
      .rdata (rd_data_o)
   );

   assign armed_o    = armed;
   assign cnt_reg_o  = {full, 1'b0, cnt};
   assign stat_reg_o = {full, {(REG_W-2){1'b0}}, armed};

   // R9
   rd_no_count_chk: assert property (@(posedge clk) disable iff (!por_n)
      (rd_req_i && !arm_set_i && !store_i && sys_rst_n) |=> $stable(cnt_reg_o));

   // R11
   disarm_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      (arm_clr_i && !arm_set_i && !store_i && sys_rst_n) |=> (!armed_o && $stable(cnt_reg_o)));
endmodule

// File: tb/trace_fill_buf_tb_top.sv
module trace_fill_buf_tb_top;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        sys_rst_n = 1'b1;
   logic        arm_set = 1'b0;
   logic        arm_clr = 1'b0;
   logic        align_end = 1'b0;
   logic        store = 1'b0;
   logic [19:0] sdata = '0;
   logic        rd_req = 1'b0;
   logic [19:0] rd_data;
   logic        rd_valid;
   logic        armed;
   logic [7:0]  cnt_reg;
   logic [7:0]  stat_reg;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   trace_fill_buf dut_i (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .arm_set_i(arm_set), .arm_clr_i(arm_clr), .align_end_i(align_end),
      .store_i(store), .store_data_i(sdata), .rd_req_i(rd_req),
      .rd_data_o(rd_data), .rd_valid_o(rd_valid), .armed_o(armed),
      .cnt_reg_o(cnt_reg), .stat_reg_o(stat_reg)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_regs(input string req, input bit full, input int cnt, input bit arm);
      check(req, "cnt_reg", {24'd0, cnt_reg}, {24'd0, full, 1'b0, 6'(cnt)});
      check(req, "stat_reg", {24'd0, stat_reg}, {24'd0, full, 6'd0, arm});
      check(req, "armed", {31'd0, armed}, {31'd0, arm});
   endtask

   task automatic pulse_arm();
      arm_set = 1'b1; @(negedge clk); arm_set = 1'b0;
   endtask

   task automatic pulse_disarm();
      arm_clr = 1'b1; @(negedge clk); arm_clr = 1'b0;
   endtask

   task automatic put(input logic [19:0] d);
      store = 1'b1; sdata = d; @(negedge clk); store = 1'b0;
   endtask

   task automatic get_expect(input string req, input logic [19:0] exp);
      rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
      check(req, "rd_valid", {31'd0, rd_valid}, 32'd1);
      check(req, "rd_data", {12'd0, rd_data}, {12'd0, exp});
   endtask

   task automatic do_por();
      por_n = 1'b0; @(negedge clk); @(negedge clk); por_n = 1'b1; @(negedge clk);
   endtask

   // R1 R10
   task automatic t_reset();
      do_por();
      check_regs("R1", 1'b0, 0, 1'b0);
      check("R1", "rd_valid", {31'd0, rd_valid}, 32'd0);
   endtask

   // R2 R8 R9 R11
   task automatic t_basic();
      align_end = 1'b1;
      for (int i = 0; i < 3; i++) put(20'hBAD00 + 20'(i));
      check_regs("R2", 1'b0, 0, 1'b0);
      pulse_arm();
      check_regs("R6", 1'b0, 0, 1'b1);
      for (int i = 0; i < 5; i++) put(20'hA0000 + 20'(i));
      check_regs("R2", 1'b0, 5, 1'b1);
      for (int i = 0; i < 5; i++) get_expect("R8", 20'hA0000 + 20'(i));
      check_regs("R9", 1'b0, 5, 1'b1);
      pulse_disarm();
      check_regs("R11", 1'b0, 5, 1'b0);
      for (int i = 0; i < 2; i++) put(20'hBAD10 + 20'(i));
      check_regs("R2", 1'b0, 5, 1'b0);
      for (int i = 0; i < 7; i++)
         if (i < 5) get_expect("R2", 20'hA0000 + 20'(i));
   endtask

   // R3 R4 R7 R8
   task automatic t_end_mode();
      align_end = 1'b1;
      pulse_arm();
      for (int i = 0; i < 64; i++) put(20'h10000 + 20'(i));
      check_regs("R3", 1'b1, 0, 1'b1);
      for (int i = 64; i < 70; i++) put(20'h10000 + 20'(i));
      check_regs("R4", 1'b1, 6, 1'b1);
      for (int i = 0; i < 64; i++) get_expect("R4", 20'h10000 + 20'(i + 6));
      check_regs("R9", 1'b1, 6, 1'b1);
      sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1;
      check_regs("R7", 1'b1, 6, 1'b0);
      put(20'hBAD20);
      check_regs("R7", 1'b1, 6, 1'b0);
      get_expect("R7", 20'h10006);
      get_expect("R7", 20'h10007);
   endtask

   // R3 R5 R6
   task automatic t_begin_mode();
      align_end = 1'b0;
      pulse_arm();
      check_regs("R6", 1'b0, 0, 1'b1);
      for (int i = 0; i < 63; i++) put(20'h20000 + 20'(i));
      check_regs("R5", 1'b0, 63, 1'b1);
      put(20'h2003F);
      check_regs("R5", 1'b1, 0, 1'b0);
      for (int i = 0; i < 3; i++) put(20'hBAD30 + 20'(i));
      check_regs("R5", 1'b1, 0, 1'b0);
      for (int i = 0; i < 64; i++) get_expect("R5", 20'h20000 + 20'(i));
      check_regs("R3", 1'b1, 0, 1'b0);
   endtask

   // R6 R7
   task automatic t_priority();
      align_end = 1'b1;
      pulse_arm();
      for (int i = 0; i < 4; i++) put(20'h30000 + 20'(i));
      arm_set = 1'b1; store = 1'b1; sdata = 20'hBAD40;
      @(negedge clk);
      arm_set = 1'b0; store = 1'b0;
      check_regs("R6", 1'b0, 0, 1'b1);
      put(20'h31111);
      check_regs("R6", 1'b0, 1, 1'b1);
      get_expect("R6", 20'h31111);
      sys_rst_n = 1'b0; arm_set = 1'b1; store = 1'b1; sdata = 20'hBAD50;
      @(negedge clk);
      sys_rst_n = 1'b1; arm_set = 1'b0; store = 1'b0;
      check_regs("R7", 1'b0, 1, 1'b0);
      get_expect("R7", 20'h31111);
   endtask

   // R1
   task automatic t_por_again();
      do_por();
      check_regs("R1", 1'b0, 0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_end_mode();
      t_begin_mode();
      t_priority();
      t_por_again();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule